// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block provides a free-running microsecond count derived from an arbitrary reference clock. A rational prescaler turns the reference into an exact average rate of one tick per microsecond. The scaling is set by a programmed ratio, a numerator (dividend) over a denominator (divisor). Each tick advances a wrapping counter that software reads through a small word-addressed register window.

Software programs the ratio once it knows the reference frequency. For example, a 19.2 MHz reference uses a 5/96 ratio, and 12 MHz uses 1/12. From then on, software only reads the count.

The prescaler keeps an accumulator. On every clock it adds the numerator. When the sum reaches the denominator, it subtracts the denominator and emits a tick. The ticks are therefore spread evenly and never drift.

Top module: `usec_timebase`

## Requirements
- R1: After synchronous active-low reset, the count is 0, the ratio register reads 0 and `bus_rvalid` is low.
- R2: The ratio register sits at byte offset 0x14. The divisor is in bits [7:0] and the dividend is in bits [15:8], and both read back as written. Bits [31:16] always read 0 and ignore written data.
- R3: Each stored ratio field holds its operand minus one. With N = min(dividend+1, divisor+1) and D = divisor+1, consider two count reads whose strobes are sampled d1 and d2 clocks after the edge of a ratio write (d1, d2 >= 2). The count advances between them by exactly floor((d2-2)·N/D) - floor((d1-2)·N/D).
- R4: The values below give the stated average rates:
  - 0x000B gives 1 increment per 12 clocks.
  - 0x000C gives 1 increment per 13 clocks.
  - 0x0019 gives 1 increment per 26 clocks.
  - 0x045F gives 5 increments per 96 clocks.
- R5: The count is read at byte offset 0x10. It is CNT_W bits wide (32 by default), zero-extended to 32 bits, and wraps modulo 2^CNT_W.
- R6: Byte offsets of the 0x60 window other than 0x10 and 0x14, and offsets beyond the window, read as 0. Writes to them change neither the ratio register nor the tick phase.
- R7: A ratio write clears the accumulator but does not alter the count value.
- R8: A ratio value of 0 is a 1/1 ratio, so the count advances on every clock. This is the reset setting.
- R9: When the dividend field exceeds the divisor field, the numerator is clamped to the denominator, giving one increment per clock.
- R10: When `bus_rd_en` is sampled high, `bus_rdata` and `bus_rvalid` present the result on the next cycle. A count read returns the value the count held at the strobe edge.
- R11: The count never advances by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one cycle |
| bus_rd_en | input | 1 | Read strobe, one cycle |
| bus_addr | input | 7 | Byte address within the window (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |

## Verification
The bench sweeps many dividend and divisor pairs, including every clamped pair in the swept range. Each pair is checked against the floor formula at uneven read gaps, so a design that rounds the ratio, forgets the n+1 encoding or lets the accumulator drift would miss by a tick. The named reference ratios are measured over whole periods: a 5/96 prescaler that collapsed to an integer divider would return the wrong count.

A ratio write is placed between two reads at full rate. A design that reset the count, or kept a stale accumulator phase, would disagree with the computed value. Stray writes to unused offsets are followed by reads of the ratio register and of the tick phase. A narrow second instance runs past its wrap point, so a counter that saturates or sign-extends shows up at once.

// File: rtl/utick_pkg.sv
// Package: shared constants and read-select encoding for the microsecond timebase.
// Assumes a 32-bit data bus and byte addressing with word-aligned registers.
package utick_pkg;
    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 'h60;   // size of the decoded register window
    localparam int OFS_COUNT = 'h10;   // microsecond count, read only
    localparam int OFS_RATIO = 'h14;   // prescaler ratio configuration

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_RATIO = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/usec_ratio_tick.sv
// Module: rational tick generator.
// Adds the clamped numerator to an accumulator each clock; when the sum
// reaches the denominator it subtracts it and raises a one-cycle tick.
// Assumes operands arrive in minus-one form; 'clear' restarts the phase.
module usec_ratio_tick #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [RATIO_W-1:0] dividend_m1,
    input  logic [RATIO_W-1:0] divisor_m1,
    output logic               tick,
    output logic [RATIO_W-1:0] acc,
    output logic [RATIO_W:0]   den
);
    localparam int OP_W  = RATIO_W + 1;
    localparam int SUM_W = RATIO_W + 2;

    logic [OP_W-1:0]    num_raw;
    logic [OP_W-1:0]    num_eff;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   den_ext;
    logic [SUM_W-1:0]   rem;
    logic               wrap;
    logic [RATIO_W-1:0] acc_next;

    // Decode operands from minus-one form and clamp numerator to denominator.
    always_comb begin
        num_raw = OP_W'(dividend_m1) + OP_W'(1);
        den     = OP_W'(divisor_m1) + OP_W'(1);
        num_eff = (num_raw > den) ? den : num_raw;
    end

    // Accumulate and decide whether this clock produces a tick.
    always_comb begin
        sum      = SUM_W'(acc) + SUM_W'(num_eff);
        den_ext  = SUM_W'(den);
        wrap     = (sum >= den_ext);
        rem      = sum - den_ext;
        acc_next = wrap ? rem[RATIO_W-1:0] : sum[RATIO_W-1:0];
    end

    // Register accumulator and tick; a configuration write restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (clear) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= acc_next;
            tick <= wrap;
        end
    end
endmodule

// File: rtl/usec_count.sv
// Module: wrapping microsecond counter.
// Advances by one on each tick and wraps modulo 2^CNT_W.
// Assumes the tick is a single-cycle pulse from the tick generator.
module usec_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Advance on tick; natural overflow provides the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/usec_regif.sv
// Module: register decode for the timebase window.
// Holds the ratio register, produces a write pulse for it, and returns
// registered read data one cycle after the strobe.
// Assumes byte addresses; the low two bits are ignored.
module usec_regif
    import utick_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [CNT_W-1:0]       count,
    output logic [2*RATIO_W-1:0]   ratio_cfg,
    output logic                   cfg_wr,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid
);
    localparam int CFG_W = 2 * RATIO_W;

    logic [ADDR_W-1:0] word_addr;
    logic              in_win;
    rd_sel_e           sel;
    logic [DATA_W-1:0] rd_mux;

    // Word-align the address and select the addressed register.
    always_comb begin
        word_addr = {addr[ADDR_W-1:2], 2'b00};
        in_win    = (int'(word_addr) < WIN_BYTES);
        if (in_win && int'(word_addr) == OFS_COUNT) begin
            sel = SEL_COUNT;
        end else if (in_win && int'(word_addr) == OFS_RATIO) begin
            sel = SEL_RATIO;
        end else begin
            sel = SEL_NONE;
        end
        cfg_wr = wr_en && (sel == SEL_RATIO);
    end

    // Read data multiplexer; undecoded and reserved bits read as zero.
    always_comb begin
        case (sel)
            SEL_COUNT: rd_mux = DATA_W'(count);
            SEL_RATIO: rd_mux = DATA_W'(ratio_cfg);
            default:   rd_mux = '0;
        endcase
    end

    // Ratio register: only the ratio fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_cfg <= '0;
        end else if (cfg_wr) begin
            ratio_cfg <= wdata[CFG_W-1:0];
        end
    end

    // Read return: capture the selected value at the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/usec_timebase.sv
// Module: fractional microsecond timebase (top).
// Connects the register decode, the rational tick generator and the
// wrapping counter. Assumes a single clock domain and synchronous reset.
module usec_timebase
    import utick_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);
    logic [2*RATIO_W-1:0] ratio_cfg;
    logic                 cfg_wr;
    logic                 tick;
    logic [RATIO_W-1:0]   acc_val;
    logic [RATIO_W:0]     den_val;
    logic [CNT_W-1:0]     count_val;

    // Register decode and read return.
    usec_regif #(
        .RATIO_W (RATIO_W),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .rd_en     (bus_rd_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .count     (count_val),
        .ratio_cfg (ratio_cfg),
        .cfg_wr    (cfg_wr),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    // Rational prescaler producing the microsecond tick.
    usec_ratio_tick #(
        .RATIO_W (RATIO_W)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cfg_wr),
        .dividend_m1 (ratio_cfg[2*RATIO_W-1:RATIO_W]),
        .divisor_m1  (ratio_cfg[RATIO_W-1:0]),
        .tick        (tick),
        .acc         (acc_val),
        .den         (den_val)
    );

    // Free-running count of ticks.
    usec_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .count (count_val)
    );
endmodule

// File: rtl/usec_timebase_chk.sv
// Module: property checker for the timebase, attached with bind below.
// Observes the bus ports together with the ratio register, accumulator,
// tick and count that separate submodules drive.
module usec_timebase_chk
    import utick_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          rdata,
    input logic                 rvalid,
    input logic                 cfg_wr,
    input logic [2*RATIO_W-1:0] ratio_cfg,
    input logic [RATIO_W-1:0]   acc,
    input logic [RATIO_W:0]     den,
    input logic                 tick,
    input logic [CNT_W-1:0]     count
);
    logic [ADDR_W-1:0] wa;
    logic              hit_count;
    logic              hit_ratio;

    // Independent address decode for the checks.
    always_comb begin
        wa        = {addr[ADDR_W-1:2], 2'b00};
        hit_count = (int'(wa) == OFS_COUNT);
        hit_ratio = (int'(wa) == OFS_RATIO);
    end

    assert_acc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, acc} < den));

    assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((count - $past(count)) <= CNT_W'(1)));

    assert_ratio_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (acc == '0 && !tick));

    assert_count_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !tick) |=> (count == $past(count)));

    assert_full_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && ratio_cfg[2*RATIO_W-1:RATIO_W] >= ratio_cfg[RATIO_W-1:0]) |=> tick);

    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    assert_count_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_count) |=> (rdata == 32'($past(count))));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ratio) |=> ((rdata >> (2*RATIO_W)) == 32'd0));

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_count && !hit_ratio) |=> (rdata == 32'd0));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(ratio_cfg));
endmodule

bind usec_timebase usec_timebase_chk #(
    .RATIO_W (RATIO_W),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .cfg_wr    (cfg_wr),
    .ratio_cfg (ratio_cfg),
    .acc       (acc_val),
    .den       (den_val),
    .tick      (tick),
    .count     (count_val)
);

// File: tb/usec_timebase_tb.sv
`timescale 1ns/1ps
module usec_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    logic        s_rd_en = 1'b0;
    logic [31:0] s_rdata;
    logic        s_rvalid;
    logic        s_wr_en = 1'b0;
    logic [31:0] s_wdata = '0;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usec_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid)
    );

    usec_timebase #(.CNT_W(8)) u_small (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(s_wr_en), .bus_rd_en(s_rd_en),
        .bus_addr(7'h10), .bus_wdata(s_wdata), .bus_rdata(s_rdata), .bus_rvalid(s_rvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic longint ticks_after(input int d, input int n, input int den);
        if (d < 2) return 0;
        return (longint'(d - 2) * n) / den;
    endfunction

    function automatic int eff_num(input logic [15:0] c);
        int n = int'(c[15:8]) + 1;
        int dd = int'(c[7:0]) + 1;
        return (n > dd) ? dd : n;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d, output int e);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        e = cyc;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [31:0] d, output int r);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        r = cyc;
        rd_en = 1'b0;
        chk(rvalid == 1'b1, "R10", "rvalid after strobe", rvalid, 1);
        d = rdata;
    endtask

    task automatic s_read(output logic [31:0] d, output int r);
        s_rd_en = 1'b1;
        @(negedge clk);
        r = cyc;
        s_rd_en = 1'b0;
        d = s_rdata;
    endtask

    // Program a ratio, then compare the count advance between two reads with the floor model (R3).
    task automatic run_ratio(input logic [15:0] c, input int g1, input int g2, input string req);
        int e0, r1, r2, n, dd;
        logic [31:0] a, b;
        longint exp;
        do_write(7'h14, {16'h0, c}, e0);
        idle(g1);
        do_read(7'h10, a, r1);
        idle(g2);
        do_read(7'h10, b, r2);
        n = eff_num(c);
        dd = int'(c[7:0]) + 1;
        exp = ticks_after(r2 - e0, n, dd) - ticks_after(r1 - e0, n, dd);
        chk(longint'(b - a) == exp, req, $sformatf("advance cfg=%04h", c), longint'(b - a), exp);
    endtask

    // Measure the advance over a whole number of periods (R4).
    task automatic run_period(input logic [15:0] c, input int span, input int exp);
        int e0, r1, r2;
        logic [31:0] a, b;
        do_write(7'h14, {16'h0, c}, e0);
        idle(3);
        do_read(7'h10, a, r1);
        idle(span - 1);
        do_read(7'h10, b, r2);
        chk((r2 - r1) == span, "R4", "window length", r2 - r1, span);
        chk(int'(b - a) == exp, "R4", $sformatf("rate cfg=%04h", c), b - a, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int e_rst, r, rb, e0, e1, sr1, sr2;
        logic [31:0] v, a, b;
        longint exp;

        repeat (4) @(negedge clk);
        chk(rvalid == 1'b0, "R1", "rvalid in reset", rvalid, 0);
        rst_n = 1'b1;
        e_rst = cyc;

        // R1: reset values of count and ratio register.
        do_read(7'h10, v, r);
        chk(v == 32'd0, "R1", "count after reset", v, 0);
        do_read(7'h14, v, r);
        chk(v == 32'd0, "R1", "ratio after reset", v, 0);
        @(negedge clk);
        chk(rvalid == 1'b0, "R10", "rvalid one cycle only", rvalid, 0);

        // R8: reset ratio counts every clock.
        idle(20);
        do_read(7'h10, v, r);
        exp = ticks_after(r - e_rst, 1, 1);
        chk(longint'(v) == exp, "R8", "full rate from reset", v, exp);

        // R5: narrow instance wraps modulo 2^8.
        s_read(a, sr1);
        idle(250);
        s_read(b, sr2);
        exp = (longint'(a) + (sr2 - sr1)) & 'hFF;
        chk(longint'(b) == exp, "R5", "wrap value", b, exp);
        chk(b < a, "R5", "wrap observed", b, a);
        chk(b[31:8] == 24'd0, "R5", "upper bits zero", b[31:8], 0);

        // R7: ratio write keeps the count; accumulator restarts.
        do_read(7'h10, v, rb);
        idle(5);
        do_write(7'h14, 32'h0, e0);
        idle(6);
        do_read(7'h10, a, r);
        exp = longint'(v) + (e0 - rb + 1) + ticks_after(r - e0, 1, 1);
        chk(longint'(a) == exp, "R7", "count kept over write", a, exp);

        // R2: field placement and reserved bits.
        do_write(7'h14, 32'hABCD_1234, e0);
        do_read(7'h14, v, r);
        chk(v == 32'h0000_1234, "R2", "ratio readback", v, 32'h1234);

        // R6: unused offsets read zero and ignore writes.
        do_write(7'h14, 32'h0000_000B, e0);
        do_write(7'h00, 32'hDEAD_BEEF, e1);
        do_write(7'h18, 32'hFFFF_FFFF, e1);
        do_write(7'h5C, 32'h1234_5678, e1);
        do_write(7'h7C, 32'hFFFF_0000, e1);
        do_read(7'h14, v, r);
        chk(v == 32'h0000_000B, "R6", "ratio after stray writes", v, 32'hB);
        do_read(7'h18, v, r);
        chk(v == 32'd0, "R6", "offset 0x18 reads zero", v, 0);
        do_read(7'h00, v, r);
        chk(v == 32'd0, "R6", "offset 0x00 reads zero", v, 0);
        do_read(7'h5C, v, r);
        chk(v == 32'd0, "R6", "offset 0x5C reads zero", v, 0);
        do_read(7'h64, v, r);
        chk(v == 32'd0, "R6", "offset 0x64 reads zero", v, 0);
        do_read(7'h10, a, sr1);
        idle(37);
        do_read(7'h10, b, sr2);
        exp = ticks_after(sr2 - e0, 1, 12) - ticks_after(sr1 - e0, 1, 12);
        chk(longint'(b - a) == exp, "R6", "phase untouched by stray writes", b - a, exp);

        // R4: named reference ratios over whole periods.
        run_period(16'h000B, 120, 10);
        run_period(16'h000C, 91, 7);
        run_period(16'h0019, 130, 5);
        run_period(16'h045F, 960, 50);

        // R9 and R11: clamped ratios give exactly one step per clock.
        foreach (u_dut.bus_wdata[i]) if (i < 1) begin end
        begin
            logic [15:0] cl [3] = '{16'hFF00, 16'h0604, 16'h0201};
            for (int k = 0; k < 3; k++) begin
                do_write(7'h14, {16'h0, cl[k]}, e0);
                idle(2);
                do_read(7'h10, a, sr1);
                idle(30 + k);
                do_read(7'h10, b, sr2);
                chk(int'(b - a) == (sr2 - sr1), "R9", "clamped full rate", b - a, sr2 - sr1);
                chk(int'(b - a) <= (sr2 - sr1), "R11", "at most one per clock", b - a, sr2 - sr1);
            end
        end

        // R3: sweep of dividend and divisor pairs with uneven gaps.
        for (int dv = 0; dv < 8; dv++) begin
            for (int ds = 0; ds < 16; ds++) begin
                run_ratio({8'(dv), 8'(ds)}, 1 + (ds % 5), 40 + dv * 13 + ds, "R3");
            end
        end
        run_ratio(16'h0433, 3, 411, "R3");
        run_ratio(16'h00FF, 2, 700, "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule